// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer with Page Status

This block caches virtual-to-physical page translations for a processor's load, store and instruction-fetch path. A lookup presents a virtual page number, a page offset and an access type. In the same cycle it returns hit or miss, the physical page number, the assembled physical address and a permission-fault flag. The status bits of the matching entry come out with the lookup result. On a miss the requester goes to the page table. When the walker returns, it writes the translation through the fill port. The buffer holds translations only and never data.

The array is organised as 256 sets of two ways, 512 entries in all, for a 26-bit virtual page number. The low 8 bits select the set. The upper 18 bits are stored and compared as the tag. Each entry keeps a valid bit, a dirty bit, a reference bit, two access-rights bits and the physical page number. Hits update the status bits at the following clock edge. A one-bit recency marker per set picks the replacement victim. A single flush input empties the whole array when the running process changes. A separate clear input resets every reference bit for the operating system's periodic sweep.

Top module: `vtlb`

## Requirements
- R1: The set is selected by the low IDX_W bits of the lookup page number and the upper bits are compared as the tag. A lookup with lk_valid high hits when either way of that set holds a valid entry with an equal tag, and lk_hit is produced combinationally in the same cycle.
- R2: On a hit, lk_ppn is the entry's physical page number and lk_pa is that page number concatenated above lk_off.
- R3: A write hit that does not fault sets the entry's dirty bit at the next clock edge. lk_dirty reports the dirty bit of the matching entry as held before that edge.
- R4: Access type codes are 2'b00 read, 2'b01 write, 2'b10 fetch, with 2'b11 treated as read. Rights bit 0 permits writes, rights bit 1 permits fetches, and reads are always permitted. lk_fault is high on a hit whose type is not permitted, and a faulting write leaves the dirty bit unchanged.
- R5: The reference bit is set by every hit, including a faulting one, and by a fill. A clr_ref pulse clears all reference bits at the next edge, but a hit or fill in that same cycle leaves its own entry's bit set. lk_ref reports the bit of the matching entry.
- R6: A flush_all pulse invalidates every entry at the next edge. A fill in the same cycle is dropped, and so are that cycle's hit status updates. The lookup in the flush cycle itself is still answered from the old contents.
- R7: When no entry matches or lk_valid is low, lk_hit is 0, and lk_miss equals lk_valid. lk_fault, lk_dirty, lk_ref, lk_ppn and lk_pa are all 0.
- R8: A fill writes a valid entry holding its tag, page number, rights, fl_dirty and a set reference bit. It replaces a valid entry of the set with the same tag if there is one, else an invalid way, else the least recently used way.
- R9: Recency is updated by every hit and every fill. The victim is chosen from the order held before the cycle. When a hit and a fill land in the same set in one cycle, the filled entry becomes the most recent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, empties the array |
| flush_all | input | 1 | Invalidate every entry (context switch) |
| clr_ref | input | 1 | Clear every reference bit |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_acc | input | 2 | Access type: 00 read, 01 write, 10 fetch |
| lk_off | input | OFF_W | Page offset passed into the physical address |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Request must go to the page table |
| lk_fault | output | 1 | Hit whose rights forbid the access |
| lk_ppn | output | PPN_W | Physical page number of the hit |
| lk_pa | output | PPN_W+OFF_W | Physical address of the hit |
| lk_dirty | output | 1 | Dirty bit of the hit entry |
| lk_ref | output | 1 | Reference bit of the hit entry |
| fl_valid | input | 1 | Fill request from the walker |
| fl_vpn | input | VPN_W | Virtual page number being filled |
| fl_ppn | input | PPN_W | Physical page number being filled |
| fl_ar | input | 2 | Rights: bit 0 write allowed, bit 1 fetch allowed |
| fl_dirty | input | 1 | Initial dirty bit of the filled entry |

## Verification
The bench builds the block with an 8-bit page number, two index bits (four sets), a 6-bit physical page number and a 4-bit offset. With only four sets, three distinct tags in one set force an eviction within a few cycles. The directed part of the run covers hit and fill colliding in one set, fill overwriting a resident tag, and flush and fill coinciding. A seeded random phase then exercises many sets in turn and is compared against a recency-ordered list model on every cycle.

// File: rtl/vtlb.sv
module vtlb #(
  parameter int VPN_W = 26,
  parameter int IDX_W = 8,
  parameter int PPN_W = 22,
  parameter int OFF_W = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush_all,
  input  logic                   clr_ref,
  input  logic                   lk_valid,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [1:0]             lk_acc,
  input  logic [OFF_W-1:0]       lk_off,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic                   lk_fault,
  output logic [PPN_W-1:0]       lk_ppn,
  output logic [PPN_W+OFF_W-1:0] lk_pa,
  output logic                   lk_dirty,
  output logic                   lk_ref,
  input  logic                   fl_valid,
  input  logic [VPN_W-1:0]       fl_vpn,
  input  logic [PPN_W-1:0]       fl_ppn,
  input  logic [1:0]             fl_ar,
  input  logic                   fl_dirty
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam logic [1:0] ACC_WR = 2'b01;
  localparam logic [1:0] ACC_FE = 2'b10;

  logic [SETS-1:0]  vld_q [2];
  logic [SETS-1:0]  drt_q [2];
  logic [SETS-1:0]  ref_q [2];
  logic [SETS-1:0]  lru_q;
  logic [TAG_W-1:0] tag_q [2][SETS];
  logic [PPN_W-1:0] ppn_q [2][SETS];
  logic [1:0]       ar_q  [2][SETS];

  logic [IDX_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [1:0]       way_hit, fl_match;
  logic             hw, fw, allowed;
  logic [PPN_W-1:0] ppn_s;
  logic [1:0]       ar_s;

  assign lk_set = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign fl_set = fl_vpn[IDX_W-1:0];
  assign fl_tag = fl_vpn[VPN_W-1:IDX_W];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign way_hit[w]  = lk_valid && vld_q[w][lk_set] && (tag_q[w][lk_set] == lk_tag);
    assign fl_match[w] = vld_q[w][fl_set] && (tag_q[w][fl_set] == fl_tag);
  end

  assign hw    = way_hit[1];
  assign ppn_s = ppn_q[hw][lk_set];
  assign ar_s  = ar_q[hw][lk_set];

  always_comb begin
    if (lk_acc == ACC_WR)      allowed = ar_s[0];
    else if (lk_acc == ACC_FE) allowed = ar_s[1];
    else                       allowed = 1'b1;
  end

  assign lk_hit   = |way_hit;
  assign lk_miss  = lk_valid && !lk_hit;
  assign lk_fault = lk_hit && !allowed;
  assign lk_ppn   = lk_hit ? ppn_s : '0;
  assign lk_pa    = lk_hit ? {ppn_s, lk_off} : '0;
  assign lk_dirty = lk_hit && drt_q[hw][lk_set];
  assign lk_ref   = lk_hit && ref_q[hw][lk_set];

  always_comb begin
    if (fl_match[0])             fw = 1'b0;
    else if (fl_match[1])        fw = 1'b1;
    else if (!vld_q[0][fl_set])  fw = 1'b0;
    else if (!vld_q[1][fl_set])  fw = 1'b1;
    else                         fw = lru_q[fl_set];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < 2; w++) begin
        vld_q[w] <= '0;
        drt_q[w] <= '0;
        ref_q[w] <= '0;
      end
      lru_q <= '0;
    end else if (flush_all) begin
      for (int w = 0; w < 2; w++) vld_q[w] <= '0;
    end else begin
      if (clr_ref)
        for (int w = 0; w < 2; w++) ref_q[w] <= '0;
      if (lk_hit) begin
        ref_q[hw][lk_set] <= 1'b1;
        if (lk_acc == ACC_WR && !lk_fault) drt_q[hw][lk_set] <= 1'b1;
        lru_q[lk_set] <= ~hw;
      end
      if (fl_valid) begin
        vld_q[fw][fl_set] <= 1'b1;
        drt_q[fw][fl_set] <= fl_dirty;
        ref_q[fw][fl_set] <= 1'b1;
        lru_q[fl_set]     <= ~fw;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fl_valid && !flush_all) begin
      tag_q[fw][fl_set] <= fl_tag;
      ppn_q[fw][fl_set] <= fl_ppn;
      ar_q[fw][fl_set]  <= fl_ar;
    end
  end

  assert_single_way_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_fault && !lk_dirty && !lk_ref && lk_ppn == '0 && lk_pa == '0));

  assert_write_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_acc == ACC_WR && !lk_fault && !flush_all && !fl_valid)
    |=> (!(lk_valid && lk_vpn == $past(lk_vpn)) || (lk_hit && lk_dirty)));

  assert_fault_keeps_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault && lk_acc == ACC_WR && !lk_dirty && !flush_all && !fl_valid)
    |=> (!(lk_valid && lk_vpn == $past(lk_vpn)) || !lk_dirty));

  assert_ref_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ref && !lk_valid && !fl_valid) |=> !lk_ref);

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_hit);

  assert_fill_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !flush_all)
    |=> (!(lk_valid && lk_vpn == $past(fl_vpn)) || (lk_hit && lk_ppn == $past(fl_ppn))));
endmodule

// File: tb/sim_vtlb.sv
module sim_vtlb;
  localparam int VPN_W = 8, IDX_W = 2, PPN_W = 6, OFF_W = 4;
  localparam int SETS = 1 << IDX_W;
  localparam logic [1:0] RD = 2'b00, WR = 2'b01, FE = 2'b10, RX = 2'b11;

  typedef struct packed {
    logic [VPN_W-IDX_W-1:0] tag;
    logic [PPN_W-1:0]       ppn;
    logic [1:0]             ar;
    logic                   d;
    logic                   r;
  } ent_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush_all = 0, clr_ref = 0, lk_valid = 0, fl_valid = 0, fl_dirty = 0;
  logic [VPN_W-1:0] lk_vpn = '0, fl_vpn = '0;
  logic [1:0] lk_acc = '0, fl_ar = '0;
  logic [OFF_W-1:0] lk_off = '0;
  logic [PPN_W-1:0] fl_ppn = '0;
  logic lk_hit, lk_miss, lk_fault, lk_dirty, lk_ref;
  logic [PPN_W-1:0] lk_ppn;
  logic [PPN_W+OFF_W-1:0] lk_pa;

  int errors = 0, checks = 0;
  bit done = 0;
  ent_t mq [SETS][$];

  always #10 clk = ~clk;

  vtlb #(.VPN_W(VPN_W), .IDX_W(IDX_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u0 (
    .clk, .rst_n, .flush_all, .clr_ref, .lk_valid, .lk_vpn, .lk_acc, .lk_off,
    .lk_hit, .lk_miss, .lk_fault, .lk_ppn, .lk_pa, .lk_dirty, .lk_ref,
    .fl_valid, .fl_vpn, .fl_ppn, .fl_ar, .fl_dirty);

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic int find(input int s, input logic [VPN_W-IDX_W-1:0] t);
    for (int i = 0; i < mq[s].size(); i++) if (mq[s][i].tag == t) return i;
    return -1;
  endfunction

  task automatic cyc(input string lbl, input logic lv, input logic [VPN_W-1:0] vpn,
                     input logic [1:0] acc, input logic [OFF_W-1:0] off,
                     input logic fv, input logic [VPN_W-1:0] fvpn, input logic [PPN_W-1:0] fppn,
                     input logic [1:0] far, input logic fd, input logic fl, input logic cr);
    int s, h, fs, fi, vi;
    logic [VPN_W-IDX_W-1:0] vt;
    bit okp, ev;
    ent_t e;
    lk_valid = lv; lk_vpn = vpn; lk_acc = acc; lk_off = off;
    fl_valid = fv; fl_vpn = fvpn; fl_ppn = fppn; fl_ar = far; fl_dirty = fd;
    flush_all = fl; clr_ref = cr;
    #1;
    s = int'(vpn[IDX_W-1:0]);
    h = lv ? find(s, vpn[VPN_W-1:IDX_W]) : -1;
    if (h >= 0) begin
      e = mq[s][h];
      okp = (acc == WR) ? e.ar[0] : (acc == FE) ? e.ar[1] : 1'b1;
      check({lbl, " R1 hit"}, int'(lk_hit), 1);
      check({lbl, " R7 miss"}, int'(lk_miss), 0);
      check({lbl, " R2 ppn"}, int'(lk_ppn), int'(e.ppn));
      check({lbl, " R2 pa"}, int'(lk_pa), int'({e.ppn, off}));
      check({lbl, " R4 fault"}, int'(lk_fault), int'(!okp));
      check({lbl, " R3 dirty"}, int'(lk_dirty), int'(e.d));
      check({lbl, " R5 ref"}, int'(lk_ref), int'(e.r));
    end else begin
      okp = 1'b1;
      check({lbl, " R1 hit"}, int'(lk_hit), 0);
      check({lbl, " R7 miss"}, int'(lk_miss), int'(lv));
      check({lbl, " R7 outputs"}, int'({lk_fault, lk_dirty, lk_ref, lk_ppn, lk_pa}), 0);
    end
    @(posedge clk); #1;
    if (fl) begin
      for (int k = 0; k < SETS; k++) mq[k].delete();
    end else begin
      if (cr) for (int k = 0; k < SETS; k++)
        for (int i = 0; i < mq[k].size(); i++) mq[k][i].r = 1'b0;
      fs = int'(fvpn[IDX_W-1:0]);
      ev = fv && find(fs, fvpn[VPN_W-1:IDX_W]) < 0 && mq[fs].size() == 2;
      vt = ev ? mq[fs][1].tag : '0;
      if (h >= 0) begin
        e = mq[s][h];
        e.r = 1'b1;
        if (acc == WR && okp) e.d = 1'b1;
        mq[s].delete(h);
        mq[s].push_front(e);
      end
      if (fv) begin
        fi = find(fs, fvpn[VPN_W-1:IDX_W]);
        if (fi >= 0) mq[fs].delete(fi);
        else if (ev) begin vi = find(fs, vt); mq[fs].delete(vi); end
        e.tag = fvpn[VPN_W-1:IDX_W]; e.ppn = fppn; e.ar = far; e.d = fd; e.r = 1'b1;
        mq[fs].push_front(e);
      end
    end
    @(negedge clk);
  endtask

  task automatic look(input string lbl, input logic [VPN_W-1:0] vpn, input logic [1:0] acc);
    cyc(lbl, 1, vpn, acc, 4'hA, 0, '0, '0, '0, 0, 0, 0);
  endtask

  task automatic fill(input string lbl, input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                      input logic [1:0] ar, input logic d);
    cyc(lbl, 0, '0, RD, '0, 1, vpn, ppn, ar, d, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look("reset R7", 8'h15, RD);
    look("reset R7", 8'h00, WR);
    fill("fill R8", 8'h05, 6'h11, 2'b00, 0);
    fill("fill R8", 8'h06, 6'h12, 2'b01, 0);
    fill("fill R8", 8'h0B, 6'h13, 2'b10, 1);
    look("read R1", 8'h05, RD);
    look("write ro R4", 8'h05, WR);
    look("after fault R4", 8'h05, RD);
    look("fetch ro R4", 8'h05, FE);
    look("code3 read R4", 8'h05, RX);
    look("write rw R3", 8'h06, WR);
    look("dirty seen R3", 8'h06, RD);
    look("fetch x R4", 8'h0B, FE);
    look("write x R4", 8'h0B, WR);
    cyc("clr ref R5", 0, '0, RD, '0, 0, '0, '0, '0, 0, 0, 1);
    look("ref cleared R5", 8'h05, RD);
    look("ref set R5", 8'h05, RD);
    cyc("clr+hit R5", 1, 8'h06, RD, 4'h3, 0, '0, '0, '0, 0, 0, 1);
    look("hit keeps ref R5", 8'h06, RD);
    look("other cleared R5", 8'h0B, RD);
    fill("conflict R8", 8'h09, 6'h21, 2'b11, 0);
    look("touch R9", 8'h05, RD);
    fill("evict R9", 8'h0D, 6'h22, 2'b11, 0);
    look("evicted R9", 8'h09, RD);
    look("kept R9", 8'h05, RD);
    look("new R8", 8'h0D, FE);
    fill("overwrite R8", 8'h05, 6'h2F, 2'b01, 0);
    look("overwrite R8", 8'h05, WR);
    look("other kept R8", 8'h0D, RD);
    cyc("hit+fill R9", 1, 8'h0D, RD, 4'h1, 1, 8'h11, 6'h30, 2'b11, 0, 0, 0);
    look("hit+fill R9", 8'h11, RD);
    look("hit+fill R9", 8'h05, RD);
    look("hit+fill R9", 8'h0D, RD);
    cyc("flush+fill R6", 1, 8'h06, WR, 4'h7, 1, 8'h02, 6'h33, 2'b11, 0, 1, 0);
    look("flushed R6", 8'h06, RD);
    look("dropped R6", 8'h02, RD);
    look("flushed R6", 8'h11, RD);
    fill("refill R8", 8'h02, 6'h34, 2'b11, 0);
    look("refill R8", 8'h02, WR);
    for (int n = 0; n < 3000; n++) begin
      logic [VPN_W-1:0] v, fvv;
      v   = {4'h0, 4'($urandom_range(0, 15))};
      fvv = {4'h0, 4'($urandom_range(0, 15))};
      cyc("random R1", 1'($urandom_range(0, 3) != 0), v, 2'($urandom_range(0, 3)), 4'($urandom),
          1'($urandom_range(0, 2) == 0), fvv, 6'($urandom), 2'($urandom), 1'($urandom),
          1'($urandom_range(0, 60) == 0), 1'($urandom_range(0, 25) == 0));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule